// File: doc/BRIEF.md
# Completion interrupt message coalescer

This block sits beside a descriptor queue manager. It watches the number of finished descriptors that software has not yet handed back. When that number climbs above a threshold that software programs, the block raises one interrupt. The interrupt is not a wire. It is a request to perform a single posted write of a programmed 32-bit word to a programmed 48-bit address. The request stays up until the downstream write path acknowledges it, and the block snapshots the address and data when it raises the request. Converting this request to a bus protocol happens outside the block.

The block has no mask bit. While servicing completions, software writes a threshold at least as large as the ring (1024 entries in typical use), and no further message can fire. When it is done, software writes a threshold of zero, which re-enables messages. One message goes out per excursion above the threshold. After an acknowledge, the block arms again only in two cases: the pending count falls to or below the threshold, or the count grows because a new descriptor completed. A count that sits still above the threshold therefore does not produce a stream of messages.

Top module: `cmc_coalescer`

## Requirements
- R1: After reset `msg_req` is low, the block is armed, and threshold, address and data registers are zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 is the threshold (bits [14:0] kept, higher bits dropped), 1 is the address low word (bits [31:0]), 2 is the address high part (bits [15:0] kept), 3 is the message data word.
- R3: On a clock edge where the block is armed, no request is outstanding and `pend_cnt` is strictly greater than the stored threshold, `msg_req` is high from the next cycle on.
- R4: A message carries `msg_addr` = {high[15:0], low[31:0]} and `msg_data` = the data register, both as they stood on the edge that raised the request.
- R5: `msg_req` stays high until it is sampled together with `msg_ack` high, and it is low in the cycle after that edge.
- R6: While a request is outstanding, `msg_addr` and `msg_data` hold their values even if the configuration registers are rewritten.
- R7: After an acknowledge, a pending count held steady above the threshold raises no further message.
- R8: With no request outstanding, a cycle in which the pending count is at or below the threshold re-arms the block, and a later excursion above the threshold raises a new message.
- R9: An increase of the pending count re-arms the block, including an increase seen while a request was still outstanding. The new message follows once the earlier one is acknowledged.
- R10: With the threshold at the ring size (1024), no message is raised for any pending count up to 1024.
- R11: Writing zero to the threshold while completions are pending raises a message two cycles after the write is presented.
- R12: With a threshold of zero, a single pending completion raises a message.
- R13: `msg_ack` while no request is outstanding has no effect on `msg_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 threshold, 1 address low, 2 address high, 3 data |
| cfg_wdata | input | 32 | Configuration write data |
| pend_cnt | input | 15 | Completed descriptors not yet released by software |
| msg_ack | input | 1 | Downstream accepted the message write |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bound checker covers the request handshake on every cycle. Once raised, a request holds until it is acknowledged and drops right after. The payload does not move while a request waits. Every new request can be traced to an armed cycle in which the count exceeded the threshold, and the block is never armed while a request is outstanding. Other properties depend on sequences of register writes and count changes, and only the bench scenarios show them. These are the masking by a ring-size threshold, re-enabling by a zero write, suppression of repeats on a flat count, re-arming on growth during an outstanding request, and the field truncation of the register writes.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  // Register select codes on cfg_sel
  typedef enum logic [1:0] {
    SEL_THRESH  = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_ADDR_HI = 2'd2,
    SEL_DATA    = 2'd3
  } cmc_sel_e;

  localparam int CMC_NUM_REGS = 4;

  // Count strictly above the threshold (both zero-extended to 32 bits)
  function automatic logic cmc_over(input logic [31:0] cnt, input logic [31:0] thr);
    return cnt > thr;
  endfunction

  // Count increased relative to the previous sample
  function automatic logic cmc_grew(input logic [31:0] now_cnt, input logic [31:0] old_cnt);
    return now_cnt > old_cnt;
  endfunction

endpackage

// File: rtl/cmc_cfg_regs.sv
module cmc_cfg_regs #(
  parameter int CNT_W  = 15,
  parameter int LO_W   = 32,
  parameter int HI_W   = 16,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CNT_W-1:0]  thr,
  output logic [LO_W-1:0]   addr_lo,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] data
);
  import cmc_pkg::*;

  localparam int NREG = CMC_NUM_REGS;

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = we && (sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr     <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
      data    <= '0;
    end else begin
      if (hit[SEL_THRESH])  thr     <= wdata[CNT_W-1:0];
      if (hit[SEL_ADDR_LO]) addr_lo <= wdata[LO_W-1:0];
      if (hit[SEL_ADDR_HI]) addr_hi <= wdata[HI_W-1:0];
      if (hit[SEL_DATA])    data    <= wdata[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/cmc_arm_ctrl.sv
module cmc_arm_ctrl #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             busy,
  output logic             armed,
  output logic             fire,
  output logic             grow_evt,
  output logic             calm_evt
);
  import cmc_pkg::*;

  logic [CNT_W-1:0] pend_q;
  logic             rearm_q;

  assign grow_evt = cmc_grew(32'(pend_cnt), 32'(pend_q));
  assign calm_evt = !cmc_over(32'(pend_cnt), 32'(thr));
  assign fire     = armed && !busy && !calm_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      pend_q  <= '0;
      rearm_q <= 1'b0;
    end else begin
      pend_q <= pend_cnt;
      // remember a re-arm reason seen while a message is outstanding
      if (armed)
        rearm_q <= 1'b0;
      else if (grow_evt || calm_evt)
        rearm_q <= 1'b1;
      if (fire)
        armed <= 1'b0;
      else if (!armed && !busy && (rearm_q || grow_evt || calm_evt))
        armed <= 1'b1;
    end
  end

endmodule

// File: rtl/cmc_msg_stage.sv
module cmc_msg_stage #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ack,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              done_evt
);

  assign done_evt = req && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      addr <= '0;
      data <= '0;
    end else if (fire) begin
      req  <= 1'b1;
      addr <= addr_in;
      data <= data_in;
    end else if (done_evt) begin
      req <= 1'b0;
    end
  end

endmodule

// File: rtl/cmc_coalescer.sv
module cmc_coalescer #(
  parameter int CNT_W  = 15,
  parameter int LO_W   = 32,
  parameter int HI_W   = 16,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [CNT_W-1:0]     pend_cnt,
  input  logic                 msg_ack,
  output logic                 msg_req,
  output logic [LO_W+HI_W-1:0] msg_addr,
  output logic [DATA_W-1:0]    msg_data
);

  localparam int ADDR_W = LO_W + HI_W;

  logic [CNT_W-1:0]  thr_w;
  logic [LO_W-1:0]   lo_w;
  logic [HI_W-1:0]   hi_w;
  logic [DATA_W-1:0] dat_w;
  logic              armed_w;
  logic              fire_w;
  logic              grow_w;
  logic              calm_w;
  logic              done_w;

  cmc_cfg_regs #(
    .CNT_W(CNT_W), .LO_W(LO_W), .HI_W(HI_W),
    .DATA_W(DATA_W), .CFG_W(CFG_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .thr(thr_w), .addr_lo(lo_w), .addr_hi(hi_w), .data(dat_w)
  );

  cmc_arm_ctrl #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .thr(thr_w),
    .busy(msg_req), .armed(armed_w), .fire(fire_w),
    .grow_evt(grow_w), .calm_evt(calm_w)
  );

  cmc_msg_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .fire(fire_w), .ack(msg_ack),
    .addr_in({hi_w, lo_w}), .data_in(dat_w),
    .req(msg_req), .addr(msg_addr), .data(msg_data), .done_evt(done_w)
  );

endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [CNT_W-1:0]  thr,
  input logic              armed,
  input logic              msg_req,
  input logic              msg_ack,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [DATA_W-1:0] msg_data
);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && !msg_ack |=> msg_req);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && msg_ack |=> !msg_req);

  // R6
  payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && !msg_ack |=> $stable(msg_addr) && $stable(msg_data));

  // R3
  fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> ($past(pend_cnt) > $past(thr)) && $past(armed));

  // R7
  no_arm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> !armed);

endmodule

bind cmc_coalescer cmc_chk #(
  .CNT_W(CNT_W), .ADDR_W(LO_W + HI_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_cnt(pend_cnt), .thr(thr_w),
  .armed(armed_w), .msg_req(msg_req), .msg_ack(msg_ack),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_cmc_coalescer.sv
module sim_cmc_coalescer;

  localparam int CNT_W = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [14:0] pend_cnt = 15'd0;
  logic        msg_ack = 1'b0;
  logic        msg_req;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmc_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pend_cnt(pend_cnt), .msg_ack(msg_ack),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // Reference state built from the requirements
  logic        m_req, m_armed, m_rearm;
  logic [14:0] m_thr, m_pend_q;
  logic [31:0] m_lo, m_dat, m_data_out;
  logic [15:0] m_hi;
  logic [47:0] m_addr_out;

  function automatic logic exceeds(input logic [14:0] c, input logic [14:0] t);
    return c > t;
  endfunction

  task automatic model_edge();
    logic grow, over, fire_e, n_req, n_armed, n_rearm;
    if (!rst_n) begin
      m_req = 0; m_armed = 1; m_rearm = 0; m_thr = 0; m_pend_q = 0;
      m_lo = 0; m_hi = 0; m_dat = 0; m_addr_out = 0; m_data_out = 0;
      return;
    end
    grow   = pend_cnt > m_pend_q;
    over   = exceeds(pend_cnt, m_thr);
    fire_e = m_armed && !m_req && over;
    if (fire_e) begin
      m_addr_out = {m_hi, m_lo};
      m_data_out = m_dat;
    end
    n_req   = fire_e ? 1'b1 : ((m_req && msg_ack) ? 1'b0 : m_req);
    n_armed = fire_e ? 1'b0 :
              ((!m_armed && !m_req && (m_rearm || grow || !over)) ? 1'b1 : m_armed);
    n_rearm = m_armed ? 1'b0 : (m_rearm || grow || !over);
    m_req = n_req; m_armed = n_armed; m_rearm = n_rearm;
    m_pend_q = pend_cnt;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: m_thr = cfg_wdata[14:0];
        2'd1: m_lo  = cfg_wdata;
        2'd2: m_hi  = cfg_wdata[15:0];
        default: m_dat = cfg_wdata;
      endcase
    end
  endtask

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(msg_req === m_req, {tag, " req"}, 64'(msg_req), 64'(m_req));
    if (m_req) begin
      chk(msg_addr === m_addr_out, {tag, " addr"}, 64'(msg_addr), 64'(m_addr_out));
      chk(msg_data === m_data_out, {tag, " data"}, 64'(msg_data), 64'(m_data_out));
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] v, input string tag);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int p;
    void'($urandom(32'd20240611));
    repeat (3) tick("R1 reset");
    rst_n = 1'b1;
    chk(msg_req == 1'b0, "R1 idle after reset", 64'(msg_req), 64'd0);
    tick("R1");
    chk(msg_req == 1'b0, "R1 no request at zero count", 64'(msg_req), 64'd0);

    // R2 R4 R12: program payload, threshold zero, one completion
    cfg_write(2'd0, 32'd0, "R12 thr");
    cfg_write(2'd1, 32'h1000_0040, "R2 lo");
    cfg_write(2'd2, 32'hABCD_1234, "R2 hi");
    cfg_write(2'd3, 32'hCAFE_0001, "R2 data");
    pend_cnt = 15'd1;
    tick("R12");
    chk(msg_req == 1'b1, "R12 single completion fires", 64'(msg_req), 64'd1);
    chk(msg_addr == 48'h1234_1000_0040, "R4 addr", 64'(msg_addr), 64'h1234_1000_0040);
    chk(msg_data == 32'hCAFE_0001, "R4 data", 64'(msg_data), 64'hCAFE_0001);

    // R6: rewrite payload while waiting
    cfg_write(2'd1, 32'h0000_DEAD, "R6");
    cfg_write(2'd3, 32'h1111_2222, "R6");
    tick("R6");
    chk(msg_addr == 48'h1234_1000_0040, "R6 addr held", 64'(msg_addr), 64'h1234_1000_0040);
    chk(msg_data == 32'hCAFE_0001, "R6 data held", 64'(msg_data), 64'hCAFE_0001);

    // R5: acknowledge
    msg_ack = 1'b1;
    tick("R5");
    msg_ack = 1'b0;
    chk(msg_req == 1'b0, "R5 drop after ack", 64'(msg_req), 64'd0);

    // R7: flat count
    repeat (8) tick("R7");
    chk(msg_req == 1'b0, "R7 no repeat on flat count", 64'(msg_req), 64'd0);

    // R9: growth re-arms, fires two edges later
    pend_cnt = 15'd2;
    tick("R9");
    tick("R9");
    chk(msg_req == 1'b1, "R9 new completion fires", 64'(msg_req), 64'd1);
    chk(msg_addr == 48'h1234_0000_DEAD, "R4 new addr", 64'(msg_addr), 64'h1234_0000_DEAD);
    msg_ack = 1'b1;
    tick("R5");
    // R13: ack with nothing outstanding
    repeat (3) tick("R13");
    msg_ack = 1'b0;
    chk(msg_req == 1'b0, "R13 stray ack ignored", 64'(msg_req), 64'd0);

    // R10: ring-size threshold masks
    cfg_write(2'd0, 32'd1024, "R10");
    pend_cnt = 15'd500;
    repeat (3) tick("R10");
    pend_cnt = 15'd1024;
    repeat (3) tick("R10");
    chk(msg_req == 1'b0, "R10 masked at ring size", 64'(msg_req), 64'd0);

    // R11: writing zero re-enables
    cfg_write(2'd0, 32'd0, "R11");
    tick("R11");
    chk(msg_req == 1'b1, "R11 zero threshold re-enables", 64'(msg_req), 64'd1);
    msg_ack = 1'b1;
    tick("R5");
    msg_ack = 1'b0;

    // R8 R2: drop below threshold, then exceed with truncated write
    cfg_write(2'd0, 32'd2000, "R8");
    tick("R8");
    cfg_write(2'd0, 32'h0001_83E8, "R2 thr truncation");
    tick("R8");
    chk(msg_req == 1'b1, "R8 R2 re-armed and fired at thr 1000", 64'(msg_req), 64'd1);
    msg_ack = 1'b1;
    tick("R5");
    msg_ack = 1'b0;

    // Constrained random phase against the reference state
    p = 1024;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 3) p = p + 1 + int'($urandom % 3);
      else if (r < 5) p = p - 1 - int'($urandom % 4);
      if (p < 0) p = 0;
      if (p > 2047) p = 2047;
      pend_cnt = 15'(p);
      r = int'($urandom % 16);
      cfg_we = 1'b0;
      if (r == 0) begin
        int k;
        k = int'($urandom % 3);
        cfg_we = 1'b1; cfg_sel = 2'd0;
        cfg_wdata = (k == 0) ? 32'd0 : ((k == 1) ? 32'd1024 : (32'(p) + ($urandom % 8)));
      end else if (r == 1) begin
        cfg_we = 1'b1; cfg_sel = 2'(1 + ($urandom % 3)); cfg_wdata = $urandom;
      end
      msg_ack = m_req && (($urandom % 3) == 0);
      tick("random R3 R5 R6 R8 R9");
    end
    cfg_we = 1'b0;
    msg_ack = 1'b0;
    finish_run();
  end

endmodule